// File: doc/BRIEF.md
# Packetizing Multi-Channel Slave Write FIFO

This block sits on the slave side of a synchronous byte interface that runs on a single clock. An external master selects one of four channel FIFOs with a two-bit channel address. It writes a byte on every rising edge where chip-select and write strobe are both high. The bytes of each channel are grouped into packets. A packet is committed to the host side in one of two ways: automatically, when its byte count reaches a programmed auto-length, or early, when the master raises the packet-end input to send a short packet.

On the host side, each channel holds a small queue of committed packet lengths. The host picks a channel with `h_sel`. It sees the length of the oldest committed packet and that packet's next byte, and steps through the bytes with `h_pop`. The packet is retired when its last byte is popped. Per-channel full, empty and sticky overflow flags come only from registered state, so they change only at a clock edge.

Each channel has two state machines. The writer is `W_EMPTY` while the open packet holds no bytes and `W_FILL` once it holds at least one. Transitions: `W_EMPTY -> W_FILL` on an accepted write that does not commit. `W_FILL -> W_EMPTY` on any commit. A commit in `W_EMPTY` (packet-end with no bytes) stays in `W_EMPTY`. The reader is `R_NONE` when no packet is committed, `R_HEAD` when it is at the first byte of the head packet, and `R_BODY` when it is part-way through. Transitions: `R_NONE -> R_HEAD` on a commit. `R_HEAD -> R_BODY` when a pop is not the last byte. `R_HEAD`/`R_BODY -> R_HEAD` when the head packet is retired and another is queued. `R_HEAD`/`R_BODY -> R_NONE` when the head packet is retired and none remain.

Top module: `pkt_slave_fifo`

## Requirements
- R1: A byte is stored in channel `m_addr` only on a rising edge where `m_sel` and `m_wr` are both 1 and that channel's full flag is 0. The host reads the bytes of a channel in the order they were written.
- R2: While `m_sel` and `m_wr` stay high, a new byte is accepted on every consecutive rising edge.
- R3: When `m_pkt_end` is high on the same accepted edge as a write, the committed packet includes that byte.
- R4: A `m_pkt_end` pulse on a cycle with no write commits the bytes held so far as a short packet.
- R5: With `auto_en`=1 and `auto_len` between 1 and DEPTH, a packet commits on the write that makes its byte count equal `auto_len`. An `auto_len` of 0 disables auto commits.
- R6: A `m_pkt_end` on the same edge as an auto commit adds no second packet.
- R7: A `m_pkt_end` with no bytes held commits a zero-length packet. It is shown with `h_desc_len`=0 and `h_last`=1, and a single `h_pop` retires it.
- R8: Only the channel equal to `m_addr` takes writes and packet-end, and only while `m_sel`=1. Other channels are unchanged.
- R9: `ch_full[i]` is 1 when channel i holds DEPTH bytes or DQ_DEPTH committed packets. Writes while it is 1 are dropped and set `ch_overflow[i]`, which stays 1 until reset. Packet-end is dropped only when the packet queue is full.
- R10: `ch_empty[i]` is 1 exactly when channel i has no committed packet. All flags change only at a clock edge.
- R11: After reset, `ch_empty` is all ones, `ch_full` and `ch_overflow` are zero, and `h_desc_valid` is 0.
- R12: For channel `h_sel`, `h_desc_valid` shows that a committed packet exists and `h_desc_len` gives its length. `h_data` is its next byte, and `h_last` marks the final byte. `h_pop` advances one byte and retires the packet after its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_sel | input | 1 | Master chip-select, active high |
| m_wr | input | 1 | Master write strobe, active high |
| m_addr | input | 2 | Channel address |
| m_data | input | 8 | Write byte |
| m_pkt_end | input | 1 | Commit the open packet now |
| auto_en | input | 1 | Enable auto commit |
| auto_len | input | 5 | Auto-commit length (0 = off) |
| h_sel | input | 2 | Host channel select |
| h_pop | input | 1 | Host takes the current byte |
| h_desc_valid | output | 1 | Selected channel has a committed packet |
| h_desc_len | output | 5 | Length of the head packet |
| h_data | output | 8 | Next byte of the head packet |
| h_last | output | 1 | Current byte is the final one (or the packet is empty) |
| ch_full | output | 4 | Per-channel full flags |
| ch_empty | output | 4 | Per-channel no-committed-packet flags |
| ch_overflow | output | 4 | Per-channel sticky dropped-write flags |

## Verification
The directed patterns cover several cases, each telling apart two behaviours: a lone write with packet-end on the same edge (byte included or left behind), and a burst followed by a later packet-end (short commit or no commit). They also cover packet-end with nothing held (zero-length packet or none), an auto commit with and without a packet-end on the same edge (one packet or two), a write to an unselected channel, and a write with chip-select low. A fill to DEPTH bytes shows whether an extra write is dropped and flagged. Constrained random traffic then mixes channels, bursts, pops and changes to the auto-length. Against a queue model, it shows ordering and interleaving faults that the fixed cases miss.

// File: rtl/pktfifo_pkg.sv
package pktfifo_pkg;
    typedef enum logic {
        W_EMPTY,
        W_FILL
    } wr_state_t;

    typedef enum logic [1:0] {
        R_NONE,
        R_HEAD,
        R_BODY
    } rd_state_t;
endpackage

// File: rtl/pkt_byte_ring.sv
module pkt_byte_ring #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [DATA_W-1:0]             push_data,
    input  logic                          pop,
    output logic [DATA_W-1:0]             head_data,
    output logic [$clog2(DEPTH):0]        fill
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wp;
    logic [PW-1:0]     rp;
    logic [CW-1:0]     cnt;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + PW'(1);
            if (pop)  rp <= rp + PW'(1);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign head_data = mem[rp];
    assign fill      = cnt;

    // R1: each accepted byte moves the write pointer one place
    assert_wr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (wp == $past(wp) + PW'(1)));

    // R9: storage never takes a byte while holding DEPTH bytes
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH)) |-> !push);

    // R12: no byte is taken out of empty storage
    assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !pop);
endmodule

// File: rtl/pkt_desc_queue.sv
module pkt_desc_queue #(
    parameter int LEN_W    = 5,
    parameter int DQ_DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [LEN_W-1:0]             push_len,
    input  logic                         pop,
    output logic [LEN_W-1:0]             head_len,
    output logic [$clog2(DQ_DEPTH):0]    cnt
);
    localparam int QP = $clog2(DQ_DEPTH);
    localparam int QC = QP + 1;

    logic [LEN_W-1:0] lens [DQ_DEPTH];
    logic [QP-1:0]    qwp;
    logic [QP-1:0]    qrp;
    logic [QC-1:0]    qcnt;

    always_ff @(posedge clk) begin
        if (push) begin
            lens[qwp] <= push_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qwp  <= '0;
            qrp  <= '0;
            qcnt <= '0;
        end else begin
            if (push) qwp <= qwp + QP'(1);
            if (pop)  qrp <= qrp + QP'(1);
            qcnt <= qcnt + QC'(push) - QC'(pop);
        end
    end

    assign head_len = lens[qrp];
    assign cnt      = qcnt;

    // R9: no commit is written into a full packet queue
    assert_dq_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (qcnt == QC'(DQ_DEPTH)) |-> !push);

    // R12: no packet is retired from an empty queue
    assert_dq_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (qcnt == '0) |-> !pop);
endmodule

// File: rtl/pkt_chan.sv
module pkt_chan
    import pktfifo_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 16,
    parameter int DQ_DEPTH = 4,
    parameter int LEN_W    = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic               pe_hit,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               auto_en,
    input  logic [LEN_W-1:0]   auto_len,
    input  logic               rd_pop,
    output logic               full,
    output logic               empty,
    output logic               overflow,
    output logic               desc_valid,
    output logic [LEN_W-1:0]   desc_len,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_last
);
    localparam int QC = $clog2(DQ_DEPTH) + 1;

    wr_state_t w_state, w_next;
    rd_state_t r_state, r_next;

    logic [LEN_W-1:0] byte_cnt;
    logic [QC-1:0]    dq_cnt;
    logic [QC-1:0]    dq_cnt_next;
    logic [LEN_W-1:0] open_len;
    logic [LEN_W-1:0] open_next;
    logic [LEN_W-1:0] rd_off;
    logic [LEN_W-1:0] hd_len;
    logic             ovf_q;

    logic accept, auto_hit, man_hit, commit;
    logic pop_ok, last_now, byte_pop, desc_pop;
    logic dq_full, byte_full;

    assign byte_full = (byte_cnt == LEN_W'(DEPTH));
    assign dq_full   = (dq_cnt == QC'(DQ_DEPTH));
    assign full      = byte_full || dq_full;
    assign empty     = (dq_cnt == '0);
    assign overflow  = ovf_q;

    // write side decisions
    assign accept    = wr_hit && !full;
    assign open_next = open_len + LEN_W'(accept);
    assign auto_hit  = accept && auto_en && (auto_len != '0) && (open_next == auto_len);
    assign man_hit   = pe_hit && !dq_full;
    assign commit    = auto_hit || man_hit;

    // read side decisions
    assign pop_ok    = rd_pop && (r_state != R_NONE);
    assign last_now  = (hd_len == '0) || (rd_off == hd_len - LEN_W'(1));
    assign byte_pop  = pop_ok && (hd_len != '0);
    assign desc_pop  = pop_ok && last_now;
    assign dq_cnt_next = dq_cnt + QC'(commit) - QC'(desc_pop);

    pkt_byte_ring #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) i_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_data (wr_data),
        .pop       (byte_pop),
        .head_data (rd_data),
        .fill      (byte_cnt)
    );

    pkt_desc_queue #(
        .LEN_W    (LEN_W),
        .DQ_DEPTH (DQ_DEPTH)
    ) i_dq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (commit),
        .push_len (open_next),
        .pop      (desc_pop),
        .head_len (hd_len),
        .cnt      (dq_cnt)
    );

    // writer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_state <= W_EMPTY;
        else        w_state <= w_next;
    end

    // writer next state
    always_comb begin
        w_next = w_state;
        unique case (w_state)
            W_EMPTY: if (accept && !commit) w_next = W_FILL;
            W_FILL:  if (commit)            w_next = W_EMPTY;
            default: w_next = W_EMPTY;
        endcase
    end

    // open packet length and sticky overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_len <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (commit)      open_len <= '0;
            else if (accept) open_len <= open_next;
            if (wr_hit && full) ovf_q <= 1'b1;
        end
    end

    // reader state register and offset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_state <= R_NONE;
            rd_off  <= '0;
        end else begin
            r_state <= r_next;
            if (desc_pop)      rd_off <= '0;
            else if (byte_pop) rd_off <= rd_off + LEN_W'(1);
        end
    end

    // reader next state
    always_comb begin
        r_next = r_state;
        unique case (r_state)
            R_NONE: if (commit) r_next = R_HEAD;
            R_HEAD, R_BODY: begin
                if (desc_pop)      r_next = (dq_cnt_next != '0) ? R_HEAD : R_NONE;
                else if (byte_pop) r_next = R_BODY;
            end
            default: r_next = R_NONE;
        endcase
    end

    // reader outputs
    always_comb begin
        desc_valid = 1'b0;
        desc_len   = '0;
        rd_last    = 1'b0;
        unique case (r_state)
            R_NONE: ;
            R_HEAD, R_BODY: begin
                desc_valid = 1'b1;
                desc_len   = hd_len;
                rd_last    = last_now;
            end
            default: ;
        endcase
    end

    // R4: the writer reports no held bytes whenever the open count is zero
    assert_writer_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (w_state == W_EMPTY) |-> (open_len == '0));

    // R12: reader state agrees with the packet queue occupancy
    assert_reader_sync_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_state != R_NONE) == (dq_cnt != '0));

    // R9: stored byte count cannot grow while full
    assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (byte_cnt <= $past(byte_cnt)));

    // R9: overflow holds once set
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R6: an auto commit adds exactly one packet even with packet-end present
    assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        auto_hit |=> (dq_cnt == $past(dq_cnt) + QC'(1) - QC'($past(desc_pop))));

    // R5: a packet never holds more bytes than storage can
    assert_open_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        open_len <= LEN_W'(DEPTH));
endmodule

// File: rtl/pkt_slave_fifo.sv
module pkt_slave_fifo #(
    parameter int N_CH     = 4,
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 16,
    parameter int DQ_DEPTH = 4,
    parameter int AW       = $clog2(N_CH),
    parameter int LEN_W    = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               m_sel,
    input  logic               m_wr,
    input  logic [AW-1:0]      m_addr,
    input  logic [DATA_W-1:0]  m_data,
    input  logic               m_pkt_end,
    input  logic               auto_en,
    input  logic [LEN_W-1:0]   auto_len,
    input  logic [AW-1:0]      h_sel,
    input  logic               h_pop,
    output logic               h_desc_valid,
    output logic [LEN_W-1:0]   h_desc_len,
    output logic [DATA_W-1:0]  h_data,
    output logic               h_last,
    output logic [N_CH-1:0]    ch_full,
    output logic [N_CH-1:0]    ch_empty,
    output logic [N_CH-1:0]    ch_overflow
);
    logic              c_valid [N_CH];
    logic [LEN_W-1:0]  c_len   [N_CH];
    logic [DATA_W-1:0] c_data  [N_CH];
    logic              c_last  [N_CH];
    logic [N_CH-1:0]   wr_hit;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic ch_match;
        logic pe_hit;
        logic rd_pop;

        assign ch_match  = m_sel && (m_addr == AW'(i));
        assign wr_hit[i] = ch_match && m_wr;
        assign pe_hit    = ch_match && m_pkt_end;
        assign rd_pop    = h_pop && (h_sel == AW'(i));

        pkt_chan #(
            .DATA_W   (DATA_W),
            .DEPTH    (DEPTH),
            .DQ_DEPTH (DQ_DEPTH),
            .LEN_W    (LEN_W)
        ) i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_hit     (wr_hit[i]),
            .pe_hit     (pe_hit),
            .wr_data    (m_data),
            .auto_en    (auto_en),
            .auto_len   (auto_len),
            .rd_pop     (rd_pop),
            .full       (ch_full[i]),
            .empty      (ch_empty[i]),
            .overflow   (ch_overflow[i]),
            .desc_valid (c_valid[i]),
            .desc_len   (c_len[i]),
            .rd_data    (c_data[i]),
            .rd_last    (c_last[i])
        );
    end

    assign h_desc_valid = c_valid[h_sel];
    assign h_desc_len   = c_len[h_sel];
    assign h_data       = c_data[h_sel];
    assign h_last       = c_last[h_sel];

    // R8: at most one channel sees a write strobe per edge
    assert_one_channel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit));

    // R10: host valid agrees with the selected channel's empty flag
    assert_valid_vs_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        h_desc_valid == !ch_empty[h_sel]);
endmodule

// File: tb/test_pkt_slave_fifo.sv
module test_pkt_slave_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 4;
    localparam int DEPTH = 16;
    localparam int DQD   = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       m_sel, m_wr, m_pkt_end, auto_en, h_pop;
    logic [1:0] m_addr, h_sel;
    logic [7:0] m_data;
    logic [4:0] auto_len;
    logic       h_desc_valid, h_last;
    logic [4:0] h_desc_len;
    logic [7:0] h_data;
    logic [3:0] ch_full, ch_empty, ch_overflow;

    int checks = 0;
    int failures = 0;

    logic [7:0] bq [NCH][$];
    int         lq [NCH][$];
    int         oc [NCH];
    int         off [NCH];
    bit         ovf [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_slave_fifo i_pkt_slave_fifo (
        .clk(clk), .rst_n(rst_n), .m_sel(m_sel), .m_wr(m_wr), .m_addr(m_addr),
        .m_data(m_data), .m_pkt_end(m_pkt_end), .auto_en(auto_en), .auto_len(auto_len),
        .h_sel(h_sel), .h_pop(h_pop), .h_desc_valid(h_desc_valid), .h_desc_len(h_desc_len),
        .h_data(h_data), .h_last(h_last), .ch_full(ch_full), .ch_empty(ch_empty),
        .ch_overflow(ch_overflow)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_full(int c);
        return (bq[c].size() == DEPTH) || (lq[c].size() == DQD);
    endfunction

    // model of one clock edge using the inputs currently driven
    task automatic model_edge();
        bit f [NCH];
        int lpre [NCH];
        for (int c = 0; c < NCH; c++) begin
            f[c] = m_full(c);
            lpre[c] = lq[c].size();
        end
        if (h_pop && lq[h_sel].size() > 0) begin
            int L = lq[h_sel][0];
            if (L == 0) void'(lq[h_sel].pop_front());
            else begin
                void'(bq[h_sel].pop_front());
                off[h_sel]++;
                if (off[h_sel] == L) begin
                    void'(lq[h_sel].pop_front());
                    off[h_sel] = 0;
                end
            end
        end
        if (m_sel) begin
            int c = m_addr;
            bit acc = 0;
            bit au, mn;
            if (m_wr && f[c]) ovf[c] = 1;
            else if (m_wr) begin
                bq[c].push_back(m_data);
                oc[c]++;
                acc = 1;
            end
            au = acc && auto_en && (auto_len != 0) && (oc[c] == auto_len);
            mn = m_pkt_end && (lpre[c] < DQD);
            if (au || mn) begin
                lq[c].push_back(oc[c]);
                oc[c] = 0;
            end
        end
    endtask

    task automatic check_all();
        for (int c = 0; c < NCH; c++) begin
            chk(ch_empty[c] == (lq[c].size() == 0), "R10 empty flag", ch_empty[c], lq[c].size() == 0);
            chk(ch_full[c] == m_full(c), "R9 full flag", ch_full[c], m_full(c));
            chk(ch_overflow[c] == ovf[c], "R9 overflow flag", ch_overflow[c], ovf[c]);
        end
        chk(h_desc_valid == (lq[h_sel].size() > 0), "R12 desc valid", h_desc_valid, lq[h_sel].size() > 0);
        if (lq[h_sel].size() > 0) begin
            int L = lq[h_sel][0];
            chk(h_desc_len == L, "R12 desc length", h_desc_len, L);
            chk(h_last == ((L == 0) || (off[h_sel] == L - 1)), "R12 last marker", h_last,
                (L == 0) || (off[h_sel] == L - 1));
            if (L > 0) chk(h_data == bq[h_sel][0], "R1 byte order", h_data, bq[h_sel][0]);
        end
    endtask

    task automatic step(input bit s, input bit w, input logic [1:0] a, input logic [7:0] d,
                        input bit pe, input logic [1:0] hs, input bit pop);
        m_sel = s; m_wr = w; m_addr = a; m_data = d; m_pkt_end = pe; h_sel = hs; h_pop = pop;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic idle(input logic [1:0] hs);
        step(0, 0, 0, 8'h00, 0, hs, 0);
    endtask

    task automatic pop1(input logic [1:0] hs);
        step(0, 0, 0, 8'h00, 0, hs, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCH; c++) begin oc[c] = 0; off[c] = 0; ovf[c] = 0; end
        rst_n = 0; m_sel = 0; m_wr = 0; m_addr = 0; m_data = 0; m_pkt_end = 0;
        auto_en = 0; auto_len = 0; h_sel = 0; h_pop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R11: reset values
        chk(ch_empty == 4'hF, "R11 empty after reset", ch_empty, 4'hF);
        chk(ch_full == 4'h0, "R11 full after reset", ch_full, 0);
        chk(ch_overflow == 4'h0, "R11 overflow after reset", ch_overflow, 0);
        chk(h_desc_valid == 1'b0, "R11 valid after reset", h_desc_valid, 0);
        check_all();

        // R3: single byte with packet-end on the same edge
        step(1, 1, 0, 8'hA1, 1, 0, 0);
        chk(h_desc_len == 1, "R3 same-edge byte included", h_desc_len, 1);
        chk(h_data == 8'hA1, "R3 same-edge data", h_data, 8'hA1);
        pop1(0);

        // R2 / R4: burst of three, idle, then packet-end alone
        step(1, 1, 0, 8'hB0, 0, 0, 0);
        step(1, 1, 0, 8'hB1, 0, 0, 0);
        step(1, 1, 0, 8'hB2, 0, 0, 0);
        idle(0);
        chk(ch_empty[0] == 1'b1, "R4 nothing committed before packet-end", ch_empty[0], 1);
        step(1, 0, 0, 8'h00, 1, 0, 0);
        chk(h_desc_len == 3, "R2 burst took three bytes", h_desc_len, 3);
        chk(h_desc_valid == 1'b1, "R4 short packet committed", h_desc_valid, 1);
        for (int k = 0; k < 3; k++) pop1(0);

        // R7: packet-end with nothing held
        step(1, 0, 0, 8'h00, 1, 0, 0);
        chk(h_desc_valid && h_desc_len == 0, "R7 zero-length packet", h_desc_len, 0);
        chk(h_last == 1'b1, "R7 zero-length last", h_last, 1);
        pop1(0);
        chk(ch_empty[0] == 1'b1, "R7 zero-length retired", ch_empty[0], 1);

        // R5: auto commit at four bytes
        auto_en = 1; auto_len = 5'd4;
        for (int k = 0; k < 3; k++) step(1, 1, 0, 8'hC0 + 8'(k), 0, 0, 0);
        chk(ch_empty[0] == 1'b1, "R5 no commit below auto length", ch_empty[0], 1);
        step(1, 1, 0, 8'hC3, 0, 0, 0);
        chk(h_desc_len == 4, "R5 auto commit length", h_desc_len, 4);

        // R6: packet-end on the auto-commit edge
        for (int k = 0; k < 3; k++) step(1, 1, 0, 8'hD0 + 8'(k), 0, 0, 0);
        step(1, 1, 0, 8'hD3, 1, 0, 0);
        for (int k = 0; k < 8; k++) pop1(0);
        chk(ch_empty[0] == 1'b1, "R6 no extra packet", ch_empty[0], 1);
        auto_en = 0; auto_len = 0;

        // R8: address selects channel, chip-select gates
        step(1, 1, 2, 8'h5C, 1, 2, 0);
        chk(ch_empty == 4'b1011, "R8 only channel 2 written", ch_empty, 4'b1011);
        step(0, 1, 1, 8'h77, 1, 1, 0);
        chk(ch_empty[1] == 1'b1, "R8 deselected write ignored", ch_empty[1], 1);
        pop1(2);

        // R9: fill channel 3, then overflow
        for (int k = 0; k < DEPTH; k++) step(1, 1, 3, 8'(k + 16), 0, 3, 0);
        chk(ch_full[3] == 1'b1, "R9 full at depth", ch_full[3], 1);
        step(1, 1, 3, 8'hEE, 0, 3, 0);
        chk(ch_overflow[3] == 1'b1, "R9 overflow set", ch_overflow[3], 1);
        step(1, 0, 3, 8'h00, 1, 3, 0);
        chk(h_desc_len == DEPTH, "R9 dropped byte not stored", h_desc_len, DEPTH);
        for (int k = 0; k < DEPTH; k++) pop1(3);
        chk(ch_overflow[3] == 1'b1, "R9 overflow sticky", ch_overflow[3], 1);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            if (n % 400 == 0) begin
                auto_en = ($urandom % 3) != 0;
                auto_len = 5'($urandom % 7);
            end
            step(($urandom % 10) < 8, ($urandom % 10) < 6, 2'($urandom), 8'($urandom),
                 ($urandom % 10) == 0, 2'($urandom), ($urandom % 2) == 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule